// File: doc/BRIEF.md
# Latched 64-bit Match Timer

This block is a system timer that sits on a simple 32-bit register bus. Its core is a free-running 64-bit up-counter. A programmable prescaler sets how often the counter advances. Software can load either 32-bit half of the count at any time, for example to restore it. Because the counter keeps moving while software reads it, a capture command copies all 64 bits into a separate pair of snapshot registers in one cycle. The two halves read afterwards therefore always belong to the same instant.

Six 32-bit compare channels watch the low word of the count. When the counter steps onto a compare value, that channel raises a sticky flag. Software clears the flag by writing a one to it. Each flag has its own enable that routes it to a dedicated interrupt output. The last channel can also act as a watchdog: when armed, its match sends a single-cycle reset request out of the block.

Top module: `match_timer64`

## Requirements
- R1: After reset, the count, the divider, the interrupt enables, the watchdog arm bit and all flags read zero, and every compare register reads 0xFFFFFFFF.
- R2: With divider value D in the register at 0x2C, the count advances by one every 2×(D+1) clock cycles. Writing the divider restarts the prescale phase.
- R3: A write with bit 0 set to the capture register at 0x30 copies the whole 64-bit count into the snapshot registers: low word at 0x34, high word at 0x38. A write with bit 0 clear captures nothing.
- R4: The snapshot registers keep their value until the next capture command, even while the count moves on or is reloaded.
- R5: A write to 0x00 replaces the low word of the count, and a write to 0x04 replaces the high word. A count write in the same cycle as a prescaler tick wins, and the count does not advance in that cycle.
- R6: Flag n (bit n of 0x20) is set on the tick that makes the low count word equal to compare register n (at 0x08+4n). It is not set again while the count stays on that value. Loading the count directly onto the value sets no flag.
- R7: Writing 0x20 clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged. A new match in the same cycle as a clear leaves the flag set.
- R8: Interrupt output n is high exactly when flag n and enable bit n (bit n of 0x24) are both set. Clearing the enable does not stop the count.
- R9: When bit 0 of 0x28 is set and channel 5 matches, the reset request output is high for exactly one cycle. It rises in the same cycle as flag 5.
- R10: The count wraps from all ones to zero, and a carry out of the low word increments the high word. No flag is raised by the wrap itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 6 | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational and free of side effects |
| irq | output | 6 | Per-channel interrupt lines, flag AND enable |
| wdog_rst | output | 1 | Single-cycle reset request from the watchdog channel |

## Verification
A wrong prescale phase or a wrong carry does not show until software captures the count. It then appears as a snapshot that drifts from the expected tick total, or as a high word off by one after a wrap. A compare that fires on the wrong tick, or fires twice, shows within a cycle as an interrupt line or a reset request that differs from the expected value. A broken clear or a broken set-over-clear priority leaves a stale or missing flag, and the next status read shows it. The bench compares the interrupt lines and the reset request on every clock. It compares every register it reads, so a fault shows at the first sample taken after it.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;

  // word indices (byte address >> 2)
  localparam logic [3:0] IDX_CNT_LO = 4'd0;
  localparam logic [3:0] IDX_CNT_HI = 4'd1;
  localparam logic [3:0] IDX_MATCH0 = 4'd2;
  localparam logic [3:0] IDX_STATUS = 4'd8;
  localparam logic [3:0] IDX_IEN    = 4'd9;
  localparam logic [3:0] IDX_WDEN   = 4'd10;
  localparam logic [3:0] IDX_DIV    = 4'd11;
  localparam logic [3:0] IDX_CAP    = 4'd12;
  localparam logic [3:0] IDX_SNAP_LO = 4'd13;
  localparam logic [3:0] IDX_SNAP_HI = 4'd14;

  function automatic logic [3:0] match_idx(input int ch);
    return IDX_MATCH0 + 4'(ch);
  endfunction

  // new status = old with W1C clears removed, then new hits added
  function automatic logic [31:0] w1c_merge(input logic [31:0] old_v,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (old_v & ~clr) | set;
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);
  localparam int PRE_W = DIV_W + 1;

  // last phase of a 2*(D+1) period is 2*D+1
  function automatic logic [PRE_W-1:0] last_phase(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_last;

  assign pre_last = last_phase(div_q);
  assign tick     = (pre_cnt == pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_cnt <= '0;
    end else if (div_wr) begin
      div_q   <= div_wdata;
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
endmodule

// File: rtl/mt_counter64.sv
module mt_counter64 #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                cap_cmd,
  output logic [2*WORD_W-1:0] cnt,
  output logic [2*WORD_W-1:0] snap,
  output logic                adv,
  output logic [WORD_W-1:0]   nxt_lo
);
  localparam int CNT_W = 2 * WORD_W;

  logic load;
  assign load   = wr_lo | wr_hi;
  assign adv    = tick & ~load;
  assign nxt_lo = cnt[WORD_W-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      if (wr_lo) cnt[WORD_W-1:0]     <= wdata;
      if (wr_hi) cnt[CNT_W-1:WORD_W] <= wdata;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (cap_cmd) snap <= cnt;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt)); // R2
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_cmd |=> snap == $past(cnt)); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_cmd |=> $stable(snap)); // R4
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank #(
  parameter int NUM_CH = 6,
  parameter int WD_CH  = 5,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic [WORD_W-1:0]        nxt_lo,
  input  logic [NUM_CH-1:0]        match_wr,
  input  logic                     ien_wr,
  input  logic                     wden_wr,
  input  logic                     st_wr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [NUM_CH*WORD_W-1:0] match_flat,
  output logic [NUM_CH-1:0]        status,
  output logic [NUM_CH-1:0]        ien,
  output logic                     wden,
  output logic [NUM_CH-1:0]        irq,
  output logic                     wdog_rst
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] clr;
  logic [WORD_W-1:0] merged;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WORD_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cmp_q <= '1;
      else if (match_wr[ch]) cmp_q <= wdata;
    end
    assign match_flat[ch*WORD_W +: WORD_W] = cmp_q;
    assign hit[ch] = adv && (nxt_lo == cmp_q);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit[ch] |=> status[ch]); // R6
  end

  assign clr    = st_wr ? wdata[NUM_CH-1:0] : '0;
  assign merged = mt_pkg::w1c_merge(WORD_W'(status), WORD_W'(clr), WORD_W'(hit));
  assign irq    = status & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      ien      <= '0;
      wden     <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      status   <= merged[NUM_CH-1:0];
      wdog_rst <= hit[WD_CH] & wden;
      if (ien_wr)  ien  <= wdata[NUM_CH-1:0];
      if (wden_wr) wden <= wdata[0];
    end
  end

  AST_WDOG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> status[WD_CH]); // R9
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst); // R9
  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && status[0]) |=> status[0]); // R7
endmodule

// File: rtl/match_timer64.sv
module match_timer64 #(
  parameter int NUM_CH = 6,
  parameter int WD_CH  = 5,
  parameter int DIV_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [5:0]  irq,
  output logic        wdog_rst
);
  import mt_pkg::*;
  localparam int CNT_W = 2 * WORD_W;

  logic [3:0]               widx;
  logic                     wr_lo, wr_hi, cap_cmd, div_wr, ien_wr, wden_wr, st_wr;
  logic [NUM_CH-1:0]        match_wr;
  logic                     tick, adv;
  logic [DIV_W-1:0]         div_q;
  logic [CNT_W-1:0]         cnt, snap;
  logic [WORD_W-1:0]        nxt_lo;
  logic [NUM_CH*WORD_W-1:0] match_flat;
  logic [NUM_CH-1:0]        status, ien, irq_i;
  logic                     wden;
  logic                     unused_lsb;

  assign widx       = bus_addr[5:2];
  assign unused_lsb = ^bus_addr[1:0];

  assign wr_lo   = bus_wr && widx == IDX_CNT_LO;
  assign wr_hi   = bus_wr && widx == IDX_CNT_HI;
  assign cap_cmd = bus_wr && widx == IDX_CAP && bus_wdata[0];
  assign div_wr  = bus_wr && widx == IDX_DIV;
  assign ien_wr  = bus_wr && widx == IDX_IEN;
  assign wden_wr = bus_wr && widx == IDX_WDEN;
  assign st_wr   = bus_wr && widx == IDX_STATUS;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mwr
    assign match_wr[ch] = bus_wr && widx == match_idx(ch);
  end

  mt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr),
    .div_wdata(bus_wdata[DIV_W-1:0]), .div_q(div_q), .tick(tick)
  );

  mt_counter64 #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .cap_cmd(cap_cmd), .cnt(cnt), .snap(snap),
    .adv(adv), .nxt_lo(nxt_lo)
  );

  mt_match_bank #(.NUM_CH(NUM_CH), .WD_CH(WD_CH), .WORD_W(WORD_W)) u_match (
    .clk(clk), .rst_n(rst_n), .adv(adv), .nxt_lo(nxt_lo),
    .match_wr(match_wr), .ien_wr(ien_wr), .wden_wr(wden_wr), .st_wr(st_wr),
    .wdata(bus_wdata), .match_flat(match_flat), .status(status), .ien(ien),
    .wden(wden), .irq(irq_i), .wdog_rst(wdog_rst)
  );

  assign irq = irq_i;

  always_comb begin
    bus_rdata = '0;
    case (widx)
      IDX_CNT_LO:  bus_rdata = cnt[WORD_W-1:0];
      IDX_CNT_HI:  bus_rdata = cnt[CNT_W-1:WORD_W];
      IDX_STATUS:  bus_rdata = WORD_W'(status);
      IDX_IEN:     bus_rdata = WORD_W'(ien);
      IDX_WDEN:    bus_rdata = WORD_W'(wden);
      IDX_DIV:     bus_rdata = WORD_W'(div_q);
      IDX_SNAP_LO: bus_rdata = snap[WORD_W-1:0];
      IDX_SNAP_HI: bus_rdata = snap[CNT_W-1:WORD_W];
      default:     bus_rdata = '0;
    endcase
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (widx == match_idx(ch)) bus_rdata = match_flat[ch*WORD_W +: WORD_W];
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> ien[0]); // R8
endmodule

// File: tb/match_timer64_tb.sv
module match_timer64_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq;
  logic        wdog_rst;

  int n_chk = 0;
  int n_fail = 0;
  int wd_seen = 0;
  bit run_chk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer64 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_cnt, m_snap;
  logic [31:0] m_cmp [6];
  logic [5:0]  m_st, m_ien;
  logic        m_wden, m_wd;
  int unsigned m_div;
  int unsigned m_phase;

  task automatic model_reset();
    m_cnt = 0; m_snap = 0; m_st = 0; m_ien = 0; m_wden = 0; m_wd = 0;
    m_div = 0; m_phase = 0;
    foreach (m_cmp[i]) m_cmp[i] = 32'hFFFF_FFFF;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit tk, ld;
      logic [5:0] hits, clr;
      logic [63:0] old_cnt;
      int a;
      a = bus_wr ? int'(bus_addr) : -1;
      old_cnt = m_cnt;
      tk = (m_phase + 1 == 2 * (m_div + 1));
      ld = (a == 'h00) || (a == 'h04);
      hits = '0;
      if (ld) begin
        if (a == 'h00) m_cnt[31:0]  = bus_wdata;
        if (a == 'h04) m_cnt[63:32] = bus_wdata;
      end else if (tk) begin
        m_cnt = m_cnt + 1;
        for (int n = 0; n < 6; n++) hits[n] = (m_cnt[31:0] == m_cmp[n]);
      end
      if (a == 'h30 && bus_wdata[0]) m_snap = old_cnt;
      m_phase = (a == 'h2C || tk) ? 0 : m_phase + 1;
      clr = (a == 'h20) ? bus_wdata[5:0] : 6'd0;
      m_st = (m_st & ~clr) | hits;
      m_wd = hits[5] && m_wden;
      for (int n = 0; n < 6; n++) if (a == 'h08 + 4*n) m_cmp[n] = bus_wdata;
      if (a == 'h24) m_ien = bus_wdata[5:0];
      if (a == 'h28) m_wden = bus_wdata[0];
      if (a == 'h2C) m_div = bus_wdata[15:0];
    end
  end

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    case (a)
      6'h00: return m_cnt[31:0];
      6'h04: return m_cnt[63:32];
      6'h20: return {26'd0, m_st};
      6'h24: return {26'd0, m_ien};
      6'h28: return {31'd0, m_wden};
      6'h2C: return m_div;
      6'h34: return m_snap[31:0];
      6'h38: return m_snap[63:32];
      default: begin
        for (int n = 0; n < 6; n++) if (a == 6'(8 + 4*n)) return m_cmp[n];
        return 32'd0;
      end
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check({26'd0, irq}, {26'd0, m_st & m_ien}, "R8 irq lines");
      check({31'd0, wdog_rst}, {31'd0, m_wd}, "R9 reset request");
      if (wdog_rst) wd_seen++;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata, model_rd(a), tag);
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // R1: reset values
    rd_exp(6'h20, 32'd0, "R1 status");
    rd_exp(6'h24, 32'd0, "R1 enables");
    rd_exp(6'h28, 32'd0, "R1 watchdog arm");
    rd_exp(6'h2C, 32'd0, "R1 divider");
    rd_exp(6'h04, 32'd0, "R1 count high");
    for (int n = 0; n < 6; n++) rd_exp(6'(8 + 4*n), 32'hFFFF_FFFF, "R1 compare");

    // R2: default rate, then a slower divider
    idle(30);
    wr(6'h30, 32'd1);
    rd(6'h34, "R2 div0 snapshot");
    wr(6'h2C, 32'd2);
    rd(6'h2C, "R2 divider readback");
    idle(61);
    wr(6'h30, 32'd1);
    rd(6'h34, "R2 div2 snapshot");
    rd(6'h00, "R2 live count");

    // R3: capture with bit0 clear does nothing; R4: snapshot holds
    wr(6'h30, 32'hFFFF_FFFE);
    rd(6'h34, "R3 no capture on bit0 clear");
    idle(25);
    rd(6'h34, "R4 snapshot holds");
    rd(6'h38, "R4 snapshot high holds");

    // R5: count writes, including back-to-back writes that overlap ticks
    wr(6'h2C, 32'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h00;
    for (int i = 0; i < 7; i++) begin
      bus_wdata = 32'h100 + i;
      @(negedge clk);
    end
    bus_wr = 1'b0;
    rd(6'h00, "R5 write beats tick");
    check(bus_rdata, 32'h106, "R5 last written low word");
    wr(6'h04, 32'h0000_00AB);
    rd(6'h04, "R5 high word load");

    // R10: wrap of low word into high word
    wr(6'h00, 32'hFFFF_FFF0);
    wr(6'h04, 32'd7);
    idle(40);
    wr(6'h30, 32'd1);
    rd(6'h38, "R10 carry into high");
    rd_exp(6'h38, 32'd8, "R10 high after wrap");
    rd(6'h34, "R10 low after wrap");
    rd(6'h20, "R6 default compares hit on all ones");
    wr(6'h20, 32'h3F);
    rd_exp(6'h20, 32'd0, "R7 clear all");

    // R6, R8: channel 0 match with interrupt enabled
    wr(6'h00, 32'd0);
    wr(6'h08, 32'd20);
    wr(6'h0C, 32'd20);
    wr(6'h24, 32'h01);
    idle(50);
    rd(6'h20, "R6 both channels flagged");
    rd_exp(6'h20, 32'h03, "R6 flags 0 and 1");
    wr(6'h20, 32'd0);
    rd_exp(6'h20, 32'h03, "R7 zero write keeps flags");
    wr(6'h20, 32'h02);
    rd_exp(6'h20, 32'h01, "R7 clear only channel 1");
    wr(6'h24, 32'h00);
    rd(6'h20, "R8 disable keeps flag");
    wr(6'h30, 32'd1);
    rd(6'h34, "R8 count still runs");

    // R6: loading onto a compare value sets no flag
    wr(6'h20, 32'h3F);
    wr(6'h10, 32'h500);
    wr(6'h00, 32'h500);
    rd(6'h20, "R6 load sets no flag");

    // R9: watchdog channel
    wr(6'h28, 32'd1);
    wr(6'h00, 32'd0);
    wr(6'h1C, 32'd15);
    wr(6'h24, 32'h20);
    idle(50);
    check(32'(wd_seen), 32'd1, "R9 single reset pulse");
    rd(6'h20, "R9 flag 5 set");

    // R2: divider write restarts phase
    wr(6'h2C, 32'd3);
    wr(6'h00, 32'd0);
    idle(33);
    wr(6'h30, 32'd1);
    rd(6'h34, "R2 div3 snapshot");
    idle(5);
    finish_run();
  end
endmodule